// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits in front of a modelled nonvolatile word array made of two equal blocks, each divided into sectors. A host drives it through a small register-style write port. Each write selects one of four targets: configuration, status, command, or the array window. It launches three kinds of operation: programming one 16-bit word, erasing one sector, and erasing one whole block. Every stored word carries six parity bits. The sequencer writes these itself when it programs a word. An erase sets both the data and the parity of the affected words to all ones.

A command runs only after three host writes in a fixed order. First comes the target word address and data, written to the array window. Next comes the command code, written to the command register. Last comes a launch bit, written to the status register. A bit in the configuration register selects the block. That bit steers reads, the busy indication, and the block captured by the first step. A misordered step, an unknown code, a write that arrives while a command runs, or a program aimed at a word that is not fully erased each raise an access-error flag and change nothing in the array. Every command holds the array busy for a parameterised number of cycles so that the lockout can be seen. At the end of that time a completion flag is raised, and the host clears it by writing a 1 to it.

Top module: `flashSeq`

## Requirements
- R1: After reset every word of both blocks reads data 0xFFFF and parity 0x3F. The busy, completion and access-error outputs are 0, and the block select is 0.
- R2: A command runs only after three writes in this order: an array-window write (hostSel=3) carrying address and data, a command write (hostSel=2) carrying the code in bits 7:0, and a status write (hostSel=1) with bit 0 set. The codes are 0x20 for program, 0x40 for sector erase and 0x41 for block erase. A program stores the captured data at the captured word.
- R3: Any of the three steps that arrives out of order sets accErr and returns the sequence to its start. The array is left unchanged.
- R4: busy rises in the cycle after the launch write and stays high for exactly CMD_CYCLES cycles. The array changes only at the clock edge where busy falls.
- R5: The completion flag doneFlag is set at the edge where a command finishes. Writing status bit 1 clears doneFlag, and writing status bit 2 clears accErr.
- R6: Each programmed word stores six parity bits, computed as follows. Place the data bits, LSB first, at codeword positions 3, 5, 6, 7, 9 to 15 and 17 to 21. Parity bit k (k=0..4) is the XOR of the data bits whose position has bit k set. Parity bit 5 is the XOR of all data bits and parity bits 0 to 4.
- R7: A program launch at a word whose data is not 0xFFFF or whose parity is not 0x3F is refused at launch. The refusal sets accErr, busy stays low, and the word is unchanged.
- R8: A sector erase sets to 0xFFFF/0x3F all SECTOR_WORDS words of the sector holding the captured address, in the captured block. All other words are unchanged.
- R9: A block erase sets every word of the captured block to 0xFFFF/0x3F and leaves the other block unchanged.
- R10: Configuration bit 0 selects the block used by reads and by busy. The block a command acts on is the one selected at the array-window step. Configuration writes are ignored while a command runs.
- R11: A command write with any code other than the three defined ones sets accErr and aborts the sequence.
- R12: While a command runs, array-window, command and launch writes set accErr and have no other effect. The running command still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe |
| hostSel | input | 2 | Write target: 0 config, 1 status, 2 command, 3 array window |
| hostAddr | input | ADDR_W | Word address within a block, used by array-window writes |
| hostWdata | input | 16 | Write data |
| rdAddr | input | ADDR_W | Word address read from the selected block |
| rdData | output | 16 | Stored data at rdAddr |
| rdParity | output | 6 | Stored parity at rdAddr |
| blockSel | output | 1 | Current block select |
| busy | output | 1 | The selected block has a command running |
| doneFlag | output | 1 | Command completion flag |
| accErr | output | 1 | Access-error flag |

## Verification
Every flag and every launch effect is registered, so each is checked one cycle after the write that causes it. This covers accErr, the cleared flags, the block select and the rising edge of busy. The array contents and doneFlag change exactly CMD_CYCLES cycles after the launch edge. The bench therefore samples busy and the untouched array at CMD_CYCLES-1 cycles after launch, and then samples again one cycle later to see the new contents and the flag. Reads are combinational from rdAddr, so they are sampled a short time after rdAddr is driven, always between clock edges.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  localparam logic [7:0] CMD_PROG   = 8'h20;
  localparam logic [7:0] CMD_SERASE = 8'h40;
  localparam logic [7:0] CMD_BERASE = 8'h41;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam logic [1:0] SEL_ARR  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GOTADDR,
    ST_GOTCMD,
    ST_RUN
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchTarget;
    logic commitProg;
    logic commitSec;
    logic commitBlk;
  } seqStrobe_t;

  // six parity bits for a 16-bit word, single-error correcting plus overall bit
  function automatic logic [5:0] calcParity(logic [15:0] d);
    logic [21:1] cw;
    logic [5:0]  p;
    int k;
    cw = '0;
    p  = '0;
    k  = 0;
    for (int pos = 1; pos <= 21; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = d[k];
        k++;
      end
    end
    for (int b = 0; b < 5; b++) begin
      for (int pos = 1; pos <= 21; pos++) begin
        if (((pos >> b) & 1) == 1) p[b] = p[b] ^ cw[pos];
      end
    end
    p[5] = (^d) ^ (^p[4:0]);
    return p;
  endfunction

endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int CMD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic [1:0] hostSel,
  input  logic [7:0] hostByte,
  input  logic       targetErased,
  output seqStrobe_t strb,
  output logic       blockSel,
  output logic       busy,
  output logic       doneFlag,
  output logic       accErr
);

  localparam int CNT_W = $clog2(CMD_CYCLES + 1);

  seqState_e        state;
  logic [7:0]       cmdReg;
  logic [CNT_W-1:0] cnt;
  logic             runBlk;
  logic             codeValid;
  logic             lastCycle;

  assign codeValid = (hostByte == CMD_PROG) || (hostByte == CMD_SERASE) ||
                     (hostByte == CMD_BERASE);
  assign lastCycle = (state == ST_RUN) && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cmdReg   <= '0;
      cnt      <= '0;
      runBlk   <= 1'b0;
      blockSel <= 1'b0;
      doneFlag <= 1'b0;
      accErr   <= 1'b0;
    end else begin
      if (hostWr) begin
        case (hostSel)
          SEL_CFG: if (state != ST_RUN) blockSel <= hostByte[0];
          SEL_STAT: begin
            if (hostByte[1]) doneFlag <= 1'b0;
            if (hostByte[2]) accErr   <= 1'b0;
            if (hostByte[0]) begin
              if (state == ST_GOTCMD) begin
                if (cmdReg == CMD_PROG && !targetErased) begin
                  accErr <= 1'b1;
                  state  <= ST_IDLE;
                end else begin
                  state <= ST_RUN;
                  cnt   <= CNT_W'(CMD_CYCLES - 1);
                end
              end else begin
                accErr <= 1'b1;
                if (state != ST_RUN) state <= ST_IDLE;
              end
            end
          end
          SEL_CMD: begin
            if (state == ST_GOTADDR && codeValid) begin
              cmdReg <= hostByte;
              state  <= ST_GOTCMD;
            end else begin
              accErr <= 1'b1;
              if (state != ST_RUN) state <= ST_IDLE;
            end
          end
          default: begin
            if (state == ST_IDLE) begin
              state  <= ST_GOTADDR;
              runBlk <= blockSel;
            end else begin
              accErr <= 1'b1;
              if (state != ST_RUN) state <= ST_IDLE;
            end
          end
        endcase
      end
      if (state == ST_RUN) begin
        if (cnt == '0) begin
          state    <= ST_IDLE;
          doneFlag <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign strb.latchTarget = hostWr && (hostSel == SEL_ARR) && (state == ST_IDLE);
  assign strb.commitProg  = lastCycle && (cmdReg == CMD_PROG);
  assign strb.commitSec   = lastCycle && (cmdReg == CMD_SERASE);
  assign strb.commitBlk   = lastCycle && (cmdReg == CMD_BERASE);
  assign busy = (state == ST_RUN) && (runBlk == blockSel);

endmodule

// File: rtl/flashSeqData.sv
module flashSeqData
  import flashSeqPkg::*;
#(
  parameter int SECTORS      = 4,
  parameter int SECTOR_WORDS = 8
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  seqStrobe_t                                   strb,
  input  logic                                         blockSel,
  input  logic [$clog2(SECTORS*SECTOR_WORDS)-1:0]      hostAddr,
  input  logic [15:0]                                  hostWdata,
  input  logic [$clog2(SECTORS*SECTOR_WORDS)-1:0]      rdAddr,
  output logic [15:0]                                  rdData,
  output logic [5:0]                                   rdParity,
  output logic                                         targetErased
);

  localparam int WPB   = SECTORS * SECTOR_WORDS;
  localparam int AW    = $clog2(WPB);
  localparam int SW    = $clog2(SECTOR_WORDS);
  localparam int TOTAL = 2 * WPB;

  logic [15:0]   memData [TOTAL];
  logic [5:0]    memPar  [TOTAL];
  logic          tgtBlk;
  logic [AW-1:0] tgtAddr;
  logic [15:0]   tgtData;
  logic [AW:0]   tgtIdx;
  logic [AW:0]   rdIdx;
  logic [TOTAL-1:0] eraseHit;

  assign tgtIdx = {tgtBlk, tgtAddr};
  assign rdIdx  = {blockSel, rdAddr};

  for (genvar g = 0; g < TOTAL; g++) begin : gHit
    localparam logic [AW:0] IDX = (AW+1)'(g);
    assign eraseHit[g] = (IDX[AW] == tgtBlk) &&
                         (strb.commitBlk ||
                          (strb.commitSec && IDX[AW-1:SW] == tgtAddr[AW-1:SW]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtBlk  <= 1'b0;
      tgtAddr <= '0;
      tgtData <= '0;
      for (int i = 0; i < TOTAL; i++) begin
        memData[i] <= 16'hFFFF;
        memPar[i]  <= 6'h3F;
      end
    end else begin
      if (strb.latchTarget) begin
        tgtBlk  <= blockSel;
        tgtAddr <= hostAddr;
        tgtData <= hostWdata;
      end
      for (int i = 0; i < TOTAL; i++) begin
        if (eraseHit[i]) begin
          memData[i] <= 16'hFFFF;
          memPar[i]  <= 6'h3F;
        end
      end
      if (strb.commitProg) begin
        memData[tgtIdx] <= tgtData;
        memPar[tgtIdx]  <= calcParity(tgtData);
      end
    end
  end

  assign rdData       = memData[rdIdx];
  assign rdParity     = memPar[rdIdx];
  assign targetErased = (memData[tgtIdx] == 16'hFFFF) && (memPar[tgtIdx] == 6'h3F);

endmodule

// File: rtl/flashSeq.sv
module flashSeq
  import flashSeqPkg::*;
#(
  parameter int SECTORS      = 4,
  parameter int SECTOR_WORDS = 8,
  parameter int CMD_CYCLES   = 4,
  localparam int ADDR_W      = $clog2(SECTORS * SECTOR_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [1:0]        hostSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [15:0]       hostWdata,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [15:0]       rdData,
  output logic [5:0]        rdParity,
  output logic              blockSel,
  output logic              busy,
  output logic              doneFlag,
  output logic              accErr
);

  seqStrobe_t ctrlStrb;
  logic       targetErased;

  flashSeqCtrl #(.CMD_CYCLES(CMD_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostWr       (hostWr),
    .hostSel      (hostSel),
    .hostByte     (hostWdata[7:0]),
    .targetErased (targetErased),
    .strb         (ctrlStrb),
    .blockSel     (blockSel),
    .busy         (busy),
    .doneFlag     (doneFlag),
    .accErr       (accErr)
  );

  flashSeqData #(.SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (ctrlStrb),
    .blockSel     (blockSel),
    .hostAddr     (hostAddr),
    .hostWdata    (hostWdata),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .rdParity     (rdParity),
    .targetErased (targetErased)
  );

endmodule

// File: rtl/flashSeqChecker.sv
module flashSeqChecker
  import flashSeqPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic              busy,
  input logic              doneFlag,
  input logic              accErr,
  input logic              blockSel,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [15:0]       rdData,
  input logic [5:0]        rdParity,
  input seqStrobe_t        strb
);

  // R3: the error flag is raised only by a host write
  assert_err_needs_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accErr) |-> $past(hostWr));

  // R5: completion follows a commit strobe from the control
  assert_done_after_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(strb.commitProg || strb.commitSec || strb.commitBlk));

  // R4: busy ends only with the completion flag set
  assert_busy_end_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);

  // R4: the array holds its contents unless a command on the viewed block just ended
  assert_array_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdAddr) && $stable(blockSel) && !$past(busy)) |->
      ($stable(rdData) && $stable(rdParity)));

  // R2: capture and the commits never coincide
  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchTarget, strb.commitProg, strb.commitSec, strb.commitBlk}));

endmodule

bind flashSeq flashSeqChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostWr   (hostWr),
  .busy     (busy),
  .doneFlag (doneFlag),
  .accErr   (accErr),
  .blockSel (blockSel),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .rdParity (rdParity),
  .strb     (ctrlStrb)
);

// File: tb/flashSeq_tb.sv
module flashSeq_tb;

  localparam int SECTORS      = 4;
  localparam int SECTOR_WORDS = 8;
  localparam int CMD_CYCLES   = 4;
  localparam int AW           = $clog2(SECTORS * SECTOR_WORDS);

  localparam logic [1:0] S_CFG = 2'd0, S_STAT = 2'd1, S_CMD = 2'd2, S_ARR = 2'd3;
  localparam logic [15:0] C_PROG = 16'h0020, C_SER = 16'h0040, C_BER = 16'h0041;

  // {block, address, data}
  localparam int NVEC = 6;
  localparam logic [21:0] PROG_VEC [NVEC] = '{
    {1'b0, 5'd0,  16'h1234},
    {1'b0, 5'd31, 16'h0000},
    {1'b1, 5'd0,  16'hA5C3},
    {1'b1, 5'd9,  16'h0001},
    {1'b0, 5'd12, 16'h8000},
    {1'b1, 5'd20, 16'hFFFE}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostWr = 1'b0;
  logic [1:0]    hostSel = '0;
  logic [AW-1:0] hostAddr = '0;
  logic [15:0]   hostWdata = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [15:0]   rdData;
  logic [5:0]    rdParity;
  logic          blockSel, busy, doneFlag, accErr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flashSeq #(.SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS), .CMD_CYCLES(CMD_CYCLES)) u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostSel(hostSel), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .rdAddr(rdAddr), .rdData(rdData), .rdParity(rdParity),
    .blockSel(blockSel), .busy(busy), .doneFlag(doneFlag), .accErr(accErr)
  );

  function automatic logic [5:0] refParity(logic [15:0] d);
    logic [4:0] syn;
    int k;
    syn = '0;
    k = 0;
    for (int pos = 1; pos <= 21; pos++) begin
      if (!(pos inside {1, 2, 4, 8, 16})) begin
        if (d[k]) syn = syn ^ pos[4:0];
        k++;
      end
    end
    return {(^d) ^ (^syn), syn};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostSel = sel; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic readChk(input logic blk, input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [5:0] p, input string req);
    wr(S_CFG, '0, {15'd0, blk});
    rdAddr = a;
    #1;
    check(rdData == d, req, rdData, d);
    check(rdParity == p, req, rdParity, p);
  endtask

  task automatic runCmd(input logic blk, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [15:0] code);
    wr(S_CFG, '0, {15'd0, blk});
    wr(S_ARR, a, d);
    wr(S_CMD, '0, code);
    wr(S_STAT, '0, 16'h0001);
    repeat (CMD_CYCLES) @(negedge clk);
    wr(S_STAT, '0, 16'h0006);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, doneFlag, accErr, blockSel} == 4'b0, "R1 flags", {busy, doneFlag, accErr, blockSel}, 0);
    readChk(1'b0, 5'd7, 16'hFFFF, 6'h3F, "R1 blk0");
    readChk(1'b1, 5'd30, 16'hFFFF, 6'h3F, "R1 blk1");

    // R4/R5/R2 timing of one program
    wr(S_CFG, '0, 16'h0000);
    rdAddr = 5'd3;
    wr(S_ARR, 5'd3, 16'h5555);
    wr(S_CMD, '0, C_PROG);
    wr(S_STAT, '0, 16'h0001);
    check(busy == 1'b1, "R4 busy after launch", busy, 1);
    repeat (CMD_CYCLES - 1) @(negedge clk);
    check(busy == 1'b1 && rdData == 16'hFFFF, "R4 busy held, array untouched", {busy, rdData}, 32'h1FFFF);
    @(negedge clk);
    check(busy == 1'b0 && doneFlag == 1'b1, "R5 done at end", {busy, doneFlag}, 1);
    check(rdData == 16'h5555, "R2 program stored", rdData, 16'h5555);
    wr(S_STAT, '0, 16'h0002);
    check(doneFlag == 1'b0, "R5 done cleared", doneFlag, 0);

    // R2/R6 table of program vectors
    for (int i = 0; i < NVEC; i++) begin
      runCmd(PROG_VEC[i][21], PROG_VEC[i][20:16], PROG_VEC[i][15:0], C_PROG);
      readChk(PROG_VEC[i][21], PROG_VEC[i][20:16], PROG_VEC[i][15:0],
              refParity(PROG_VEC[i][15:0]), "R6 R2 vector");
    end

    // R7 program over non-erased word
    wr(S_CFG, '0, 16'h0000);
    wr(S_ARR, 5'd0, 16'h0000);
    wr(S_CMD, '0, C_PROG);
    wr(S_STAT, '0, 16'h0001);
    check(accErr == 1'b1 && busy == 1'b0, "R7 refused", {accErr, busy}, 2);
    readChk(1'b0, 5'd0, 16'h1234, refParity(16'h1234), "R7 unchanged");
    wr(S_STAT, '0, 16'h0004);
    check(accErr == 1'b0, "R5 accErr cleared", accErr, 0);

    // R3 out-of-order steps
    wr(S_CMD, '0, C_PROG);
    check(accErr == 1'b1, "R3 cmd first", accErr, 1);
    wr(S_STAT, '0, 16'h0004);
    wr(S_ARR, 5'd5, 16'h0F0F);
    wr(S_STAT, '0, 16'h0001);
    check(accErr == 1'b1, "R3 launch without cmd", accErr, 1);
    wr(S_STAT, '0, 16'h0004);
    wr(S_CMD, '0, C_PROG);
    check(accErr == 1'b1, "R3 sequence aborted", accErr, 1);
    readChk(1'b0, 5'd5, 16'hFFFF, 6'h3F, "R3 no change");
    wr(S_STAT, '0, 16'h0004);

    // R11 unknown code
    wr(S_ARR, 5'd5, 16'h0F0F);
    wr(S_CMD, '0, 16'h0033);
    check(accErr == 1'b1, "R11 bad code", accErr, 1);
    wr(S_STAT, '0, 16'h0001);
    check(busy == 1'b0, "R11 no launch", busy, 0);
    wr(S_STAT, '0, 16'h0004);

    // R8 sector erase of block 0 sector 0 with R12/R10 lockout
    wr(S_CFG, '0, 16'h0000);
    wr(S_ARR, 5'd2, 16'h0000);
    wr(S_CMD, '0, C_SER);
    wr(S_STAT, '0, 16'h0001);
    wr(S_ARR, 5'd1, 16'h0000);
    check(accErr == 1'b1 && busy == 1'b1, "R12 write during run", {accErr, busy}, 3);
    wr(S_CFG, '0, 16'h0001);
    check(blockSel == 1'b0, "R10 config ignored in run", blockSel, 0);
    repeat (CMD_CYCLES) @(negedge clk);
    check(doneFlag == 1'b1, "R12 run completes", doneFlag, 1);
    wr(S_STAT, '0, 16'h0006);
    readChk(1'b0, 5'd0, 16'hFFFF, 6'h3F, "R8 erased w0");
    readChk(1'b0, 5'd3, 16'hFFFF, 6'h3F, "R8 erased w3");
    readChk(1'b0, 5'd12, 16'h8000, refParity(16'h8000), "R8 other sector");
    readChk(1'b0, 5'd31, 16'h0000, refParity(16'h0000), "R8 last sector");
    readChk(1'b1, 5'd0, 16'hA5C3, refParity(16'hA5C3), "R8 other block");

    // R9 block erase of block 1, launched with block 0 selected (R10)
    wr(S_CFG, '0, 16'h0001);
    wr(S_ARR, 5'd0, 16'h0000);
    wr(S_CFG, '0, 16'h0000);
    wr(S_CMD, '0, C_BER);
    wr(S_STAT, '0, 16'h0001);
    check(busy == 1'b0 && accErr == 1'b0, "R10 busy only for selected block", {busy, accErr}, 0);
    repeat (CMD_CYCLES) @(negedge clk);
    check(doneFlag == 1'b1, "R9 done", doneFlag, 1);
    wr(S_STAT, '0, 16'h0006);
    readChk(1'b1, 5'd0, 16'hFFFF, 6'h3F, "R9 blk1 w0");
    readChk(1'b1, 5'd9, 16'hFFFF, 6'h3F, "R9 blk1 w9");
    readChk(1'b1, 5'd20, 16'hFFFF, 6'h3F, "R9 blk1 w20");
    readChk(1'b0, 5'd31, 16'h0000, refParity(16'h0000), "R9 blk0 kept");
    readChk(1'b0, 5'd12, 16'h8000, refParity(16'h8000), "R9 blk0 kept");

    finishRun();
  end

endmodule